// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM refreshed and brings it up safely after reset. It uses the strobe-ordered refresh form (column strobe asserted before row strobe, write enable held inactive). In this form the DRAM steps its own internal row counter, so the block never drives an address. An interval timer adds one owed refresh every `REF_INTERVAL_CYC` clock cycles. With the default values this is about 15.6 µs at 100 MHz, which spreads 2048 refreshes across each 32 ms window.

The block shares the DRAM pins with an access sequencer through a simple request/grant pair. While any refresh is owed it raises `busReq`. The sequencer closes its open row and then answers with `busGnt`. The block then drives one refresh after another until nothing is owed, and it releases the request after the last precharge. Owed refreshes pile up in a saturating counter. A burst of traffic therefore delays refreshes but does not lose them, up to `MAX_OWED` of them.

After reset the block stays silent for `INIT_PAUSE_CYC` cycles. The default is 200 µs at 100 MHz. It then owes `INIT_REFS` refreshes and issues them once granted. `initDone` stays low until that sequence completes. Normal traffic must be held off until `initDone` goes high.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rstN` is low, `rasN`, `casN` and `weN` are 1, and `busReq` and `initDone` are 0.
- R2: After reset is released, `busReq` stays 0 for exactly `INIT_PAUSE_CYC` clock cycles and rises at the end of that pause. No strobe moves during the pause, whatever `busGnt` does.
- R3: Once the pause ends, exactly `INIT_REFS` refreshes are owed. When granted they run back to back. `initDone` rises on the edge that ends the last precharge, and it stays 1 until the next reset. The interval timer does not run before `initDone` is 1.
- R4: Each refresh takes three phases, each one the given number of cycles long, in this order:
  - `casN`=0 and `rasN`=1 for `CAS_LEAD_CYC` cycles.
  - `casN`=0 and `rasN`=0 for `RAS_LOW_CYC` cycles.
  - `casN`=1 and `rasN`=1 for `PRECHARGE_CYC` cycles.

  `rasN` never falls unless `casN` was already low in the cycle before. `weN` is 1 at all times.
- R5: Once `initDone` is 1, one refresh becomes owed every `REF_INTERVAL_CYC` cycles. The first one is owed `REF_INTERVAL_CYC` cycles after `initDone` rises. `busReq` is 1 whenever a refresh is owed.
- R6: The owed count saturates at `MAX_OWED`. A grant runs every owed refresh back to back, so a burst of N refreshes lasts N×(`CAS_LEAD_CYC`+`RAS_LOW_CYC`+`PRECHARGE_CYC`)+1 cycles from grant to `busReq` low. `busReq` stays 1 until the last precharge ends.
- R7: A refresh starts only on an edge where `busGnt` is 1 and a refresh is owed. `busGnt` while nothing is owed has no effect: no strobe moves and `busReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busGnt | input | 1 | Grant from the access sequencer, row closed and pins free |
| busReq | output | 1 | Request for the DRAM pins, high while refreshes are owed or running |
| initDone | output | 1 | Power-up pause and initial refreshes complete |
| rasN | output | 1 | Row strobe to the DRAM, active low |
| casN | output | 1 | Column strobe to the DRAM, active low |
| weN | output | 1 | Write enable to the DRAM, held high |

## Verification
The bench builds the block with a 20-cycle pause and a 60-cycle refresh interval. It uses phases of 2, 3 and 2 cycles, 8 initial refreshes and an owed-count cap of 3. These short values bring the whole power-up sequence and several intervals within a few hundred cycles. They also let the owed count be walked from one refresh up to past its cap by holding the grant back for a varying number of intervals. Each refresh is then timed phase by phase, and a grant given with nothing owed is shown to leave the pins alone.

// File: rtl/dram_refresh_sched_pkg.sv
package dram_refresh_sched_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_LEAD,
    ST_STROBE,
    ST_PRE
  } seqState_t;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_STROBE,
    PH_PRE
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      loadInit;
    logic      startPhase;
    phaseSel_t phase;
    logic      retire;
  } seqCmd_t;

endpackage

// File: rtl/dram_refresh_sched_dp.sv
module dram_refresh_sched_dp
  import dram_refresh_sched_pkg::*;
#(
  parameter int INIT_PAUSE_CYC   = 20000,
  parameter int REF_INTERVAL_CYC = 1560,
  parameter int INIT_REFS        = 8,
  parameter int MAX_OWED         = 8,
  parameter int CAS_LEAD_CYC     = 2,
  parameter int RAS_LOW_CYC      = 5,
  parameter int PRECHARGE_CYC    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  seqCmd_t cmd,
  input  logic    initDone,
  output logic    pauseDone,
  output logic    phaseDone,
  output logic    owedZero
);

  localparam int OWED_CAP  = (INIT_REFS > MAX_OWED) ? INIT_REFS : MAX_OWED;
  localparam int OW        = $clog2(OWED_CAP + 1);
  localparam int PSW       = (INIT_PAUSE_CYC > 2) ? $clog2(INIT_PAUSE_CYC) : 1;
  localparam int IW        = (REF_INTERVAL_CYC > 2) ? $clog2(REF_INTERVAL_CYC) : 1;
  localparam int PH_MAX_A  = (CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC;
  localparam int PH_MAX    = (PH_MAX_A > PRECHARGE_CYC) ? PH_MAX_A : PRECHARGE_CYC;
  localparam int PW        = (PH_MAX > 2) ? $clog2(PH_MAX) : 1;

  localparam logic [OW-1:0]  INIT_LOAD  = OW'(INIT_REFS);
  localparam logic [OW-1:0]  OWED_LIMIT = OW'(MAX_OWED);
  localparam logic [PSW-1:0] PAUSE_LAST = PSW'(INIT_PAUSE_CYC - 1);
  localparam logic [IW-1:0]  IV_LAST    = IW'(REF_INTERVAL_CYC - 1);
  localparam logic [PW-1:0]  LEAD_LAST  = PW'(CAS_LEAD_CYC - 1);
  localparam logic [PW-1:0]  LOW_LAST   = PW'(RAS_LOW_CYC - 1);
  localparam logic [PW-1:0]  PRE_LAST   = PW'(PRECHARGE_CYC - 1);

  logic [PSW-1:0] pauseCnt;
  logic [IW-1:0]  ivCnt;
  logic [PW-1:0]  phCnt;
  logic [OW-1:0]  owed;
  logic           ivTick;
  logic           addOwed;

  assign pauseDone = (pauseCnt == PAUSE_LAST);
  assign phaseDone = (phCnt == '0);
  assign owedZero  = (owed == '0);
  assign ivTick    = initDone && (ivCnt == IV_LAST);
  assign addOwed   = ivTick && (owed < OWED_LIMIT);

  // power-up pause timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pauseCnt <= '0;
    else if (!pauseDone) pauseCnt <= pauseCnt + 1'b1;
  end

  // refresh interval timer, idle until init completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ivCnt <= '0;
    else if (ivTick)   ivCnt <= '0;
    else if (initDone) ivCnt <= ivCnt + 1'b1;
  end

  // one shared down-counter times every strobe phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phCnt <= '0;
    else if (cmd.startPhase) begin
      case (cmd.phase)
        PH_LEAD:   phCnt <= LEAD_LAST;
        PH_STROBE: phCnt <= LOW_LAST;
        default:   phCnt <= PRE_LAST;
      endcase
    end else if (!phaseDone) phCnt <= phCnt - 1'b1;
  end

  // owed refresh count, saturating on timer ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owed <= '0;
    else if (cmd.loadInit) owed <= INIT_LOAD;
    else begin
      case ({addOwed, cmd.retire})
        2'b10:   owed <= owed + 1'b1;
        2'b01:   owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  // R6: once running, the owed count never exceeds its cap
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (owed <= OWED_LIMIT));

endmodule

// File: rtl/dram_refresh_sched_ctl.sv
module dram_refresh_sched_ctl
  import dram_refresh_sched_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busGnt,
  input  logic    pauseDone,
  input  logic    phaseDone,
  input  logic    owedZero,
  output seqCmd_t cmd,
  output logic    busReq,
  output logic    initDone,
  output logic    rasN,
  output logic    casN,
  output logic    weN
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    case (state)
      ST_PAUSE: if (pauseDone) begin
        cmd.loadInit = 1'b1;
        stateNext    = ST_IDLE;
      end
      ST_IDLE: if (!owedZero && busGnt) begin
        cmd.startPhase = 1'b1;
        cmd.phase      = PH_LEAD;
        stateNext      = ST_LEAD;
      end
      ST_LEAD: if (phaseDone) begin
        cmd.startPhase = 1'b1;
        cmd.phase      = PH_STROBE;
        stateNext      = ST_STROBE;
      end
      ST_STROBE: if (phaseDone) begin
        cmd.startPhase = 1'b1;
        cmd.phase      = PH_PRE;
        cmd.retire     = 1'b1;
        stateNext      = ST_PRE;
      end
      ST_PRE: if (phaseDone) begin
        if (!owedZero && busGnt) begin
          cmd.startPhase = 1'b1;
          cmd.phase      = PH_LEAD;
          stateNext      = ST_LEAD;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= stateNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initDone <= 1'b0;
    else if (state == ST_PRE && phaseDone && owedZero) initDone <= 1'b1;
  end

  assign busReq = (state == ST_LEAD) || (state == ST_STROBE) || (state == ST_PRE) ||
                  ((state == ST_IDLE) && !owedZero);
  assign casN   = !((state == ST_LEAD) || (state == ST_STROBE));
  assign rasN   = !(state == ST_STROBE);
  assign weN    = 1'b1;

  // R4: row strobe falls only after the column strobe was already low
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !$past(casN));

  // R4: column strobe held low through the whole row-strobe pulse
  a_r4_cas_held: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  // R7: a refresh starts only after a grant
  a_r7_start_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> $past(busGnt));

  // R3: init-done never drops until reset
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R5: an owed refresh always keeps the request up
  a_r5_req_while_owed: assert property (@(posedge clk) disable iff (!rstN)
    !owedZero |-> busReq);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_sched_pkg::*;
#(
  parameter int INIT_PAUSE_CYC   = 20000,
  parameter int REF_INTERVAL_CYC = 1560,
  parameter int INIT_REFS        = 8,
  parameter int MAX_OWED         = 8,
  parameter int CAS_LEAD_CYC     = 2,
  parameter int RAS_LOW_CYC      = 5,
  parameter int PRECHARGE_CYC    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic busGnt,
  output logic busReq,
  output logic initDone,
  output logic rasN,
  output logic casN,
  output logic weN
);

  seqCmd_t cmd;
  logic    pauseDone;
  logic    phaseDone;
  logic    owedZero;

  dram_refresh_sched_dp #(
    .INIT_PAUSE_CYC  (INIT_PAUSE_CYC),
    .REF_INTERVAL_CYC(REF_INTERVAL_CYC),
    .INIT_REFS       (INIT_REFS),
    .MAX_OWED        (MAX_OWED),
    .CAS_LEAD_CYC    (CAS_LEAD_CYC),
    .RAS_LOW_CYC     (RAS_LOW_CYC),
    .PRECHARGE_CYC   (PRECHARGE_CYC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .initDone (initDone),
    .pauseDone(pauseDone),
    .phaseDone(phaseDone),
    .owedZero (owedZero)
  );

  dram_refresh_sched_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .busGnt   (busGnt),
    .pauseDone(pauseDone),
    .phaseDone(phaseDone),
    .owedZero (owedZero),
    .cmd      (cmd),
    .busReq   (busReq),
    .initDone (initDone),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN)
  );

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int P_PAUSE    = 20;
  localparam int P_IV       = 60;
  localparam int P_INIT     = 8;
  localparam int P_MAXO     = 3;
  localparam int P_LEAD     = 2;
  localparam int P_LOW      = 3;
  localparam int P_PRE      = 2;
  localparam int REF_LEN    = P_LEAD + P_LOW + P_PRE;
  localparam int NV         = 5;
  // {extra intervals the grant is withheld, expected refreshes in burst}
  localparam int VEC [NV][2] = '{'{0, 1}, '{1, 2}, '{2, 3}, '{3, 3}, '{5, 3}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busGnt = 1'b0;
  logic busReq, initDone, rasN, casN, weN;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_sched #(
    .INIT_PAUSE_CYC  (P_PAUSE),
    .REF_INTERVAL_CYC(P_IV),
    .INIT_REFS       (P_INIT),
    .MAX_OWED        (P_MAXO),
    .CAS_LEAD_CYC    (P_LEAD),
    .RAS_LOW_CYC     (P_LOW),
    .PRECHARGE_CYC   (P_PRE)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busGnt(busGnt), .busReq(busReq),
    .initDone(initDone), .rasN(rasN), .casN(casN), .weN(weN)
  );

  int checks = 0;
  int failures = 0;
  int rasFalls = 0;
  int casOrderBad = 0;
  int weLowSeen = 0;
  logic prevRas = 1'b1;
  logic prevCas = 1'b1;

  // strobe monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevRas && !rasN) begin
        rasFalls++;
        if (prevCas) casOrderBad++;
      end
      if (!weN) weLowSeen++;
    end
    prevRas = rasN;
    prevCas = casN;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic checkEq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic waitReq(output int n);
    n = 0;
    while (!busReq && n < 500) begin
      step();
      n++;
    end
  endtask

  task automatic runBurst(output int n);
    n = 0;
    while (busReq && n < 500) begin
      step();
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int base;
    logic lastInit;

    // R1 reset state
    repeat (3) step();
    checkEq("R1 rasN in reset", int'(rasN), 1);
    checkEq("R1 casN in reset", int'(casN), 1);
    checkEq("R1 weN in reset", int'(weN), 1);
    checkEq("R1 busReq in reset", int'(busReq), 0);
    checkEq("R1 initDone in reset", int'(initDone), 0);

    // R2 pause length
    rstN = 1'b1;
    repeat (P_PAUSE - 1) step();
    checkEq("R2 busReq during pause", int'(busReq), 0);
    step();
    checkEq("R2 busReq after pause", int'(busReq), 1);

    // R7 no refresh while grant withheld; R3 timer idle before init
    base = rasFalls;
    repeat (100) step();
    checkEq("R7 refreshes without grant", rasFalls - base, 0);
    checkEq("R3 initDone before init refreshes", int'(initDone), 0);

    // R3 init burst
    busGnt = 1'b1;
    lastInit = 1'b0;
    n = 0;
    while (busReq && n < 500) begin
      lastInit = initDone;
      step();
      n++;
    end
    checkEq("R3 init burst cycles", n, P_INIT * REF_LEN + 1);
    checkEq("R3 init refresh count", rasFalls - base, P_INIT);
    checkEq("R3 initDone after last precharge", int'(initDone), 1);
    checkEq("R3 initDone one cycle earlier", int'(lastInit), 0);
    busGnt = 1'b0;

    // R5 first interval
    repeat (P_IV - 1) step();
    checkEq("R5 busReq before first interval", int'(busReq), 0);
    step();
    checkEq("R5 busReq at first interval", int'(busReq), 1);

    // R6 table: owed count grows per interval and saturates
    for (int v = 0; v < NV; v++) begin
      if (v > 0) begin
        waitReq(n);
        checkEq("R5 request at next interval", int'(busReq), 1);
      end
      repeat (VEC[v][0] * P_IV + 10) step();
      base = rasFalls;
      busGnt = 1'b1;
      runBurst(n);
      busGnt = 1'b0;
      checkEq("R6 burst refresh count", rasFalls - base, VEC[v][1]);
      checkEq("R6 burst cycles", n, VEC[v][1] * REF_LEN + 1);
    end

    // R4 strobe shape of one refresh
    waitReq(n);
    busGnt = 1'b1;
    for (int i = 0; i <= REF_LEN; i++) begin
      int expRas;
      int expCas;
      int expReq;
      step();
      expRas = (i >= P_LEAD && i < P_LEAD + P_LOW) ? 0 : 1;
      expCas = (i < P_LEAD + P_LOW) ? 0 : 1;
      expReq = (i < REF_LEN) ? 1 : 0;
      checkEq("R4 rasN/casN/busReq per cycle", int'({busReq, rasN, casN}),
              (expReq << 2) | (expRas << 1) | expCas);
    end

    // R7 grant with nothing owed is ignored
    base = rasFalls;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (!casN || busReq) n++;
    end
    checkEq("R7 grant with nothing owed, refreshes", rasFalls - base, 0);
    checkEq("R7 grant with nothing owed, active cycles", n, 0);
    busGnt = 1'b0;

    checkEq("R4 weN low cycles", weLowSeen, 0);
    checkEq("R4 ras fell without cas low", casOrderBad, 0);
    checkEq("R3 initDone stays high", int'(initDone), 1);

    // R1/R2 reset mid-run restarts the sequence
    rstN = 1'b0;
    step();
    checkEq("R1 initDone after reset", int'(initDone), 0);
    checkEq("R1 busReq after reset", int'(busReq), 0);
    step();
    rstN = 1'b1;
    busGnt = 1'b1;
    base = rasFalls;
    repeat (P_PAUSE - 1) step();
    checkEq("R2 busReq in pause with grant", int'(busReq), 0);
    checkEq("R2 strobes quiet in pause", rasFalls - base, 0);
    busGnt = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule